// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product. It takes a new operand pair on every clock cycle and has no stall path. The partial-product bits come from AND gates: bit j of a row is multiplicand bit j AND multiplier bit i. W rows of full adders reduce them in carry-save form. Each row passes a sum vector, which stays in its column, and a carry vector, which moves one column left, to the row below. A register stage sits after every row.

At each row the least significant column of the running sum has no further additions to come. That bit is taken off as one low product bit. It then travels down the pipeline next to the remaining sum and carry vectors. The operand bits that later rows still need travel down on delay chains. After the last row, a W-bit ripple carry-propagate adder merges the sum and carry vectors into the upper half of the product. The low half is the bits already resolved.

A valid flag moves with each operand pair, one stage per cycle, so the latency is fixed and results leave in the order they entered. The design spends extra registers, area and power to reach a throughput of one product per clock.

Top module: `csa_array_mult`

## Requirements
- R1: Whenever `out_valid` is high, `product` equals the unsigned product `a*b` of the pair it belongs to, zero-extended to 2W bits.
- R2: A pair sampled at clock edge N with `in_valid` high appears on `product`, with `out_valid` high, just after edge N+W (W+1 register stages). `out_valid` is high in no other cycle.
- R3: A pair is accepted on every cycle that `in_valid` is high, including long runs of consecutive cycles. No result is dropped or repeated, and results leave in the same order the pairs entered.
- R4: While `rst_n` is low, and after it is released until the first result, `out_valid` is 0 and `product` is all zeros.
- R5: In every cycle where `out_valid` is low, `product` keeps the value it had in the previous cycle.
- R6: The largest operands, `a` = `b` = 2^W-1, give (2^W-1)^2, and the final adder never carries out beyond bit 2W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `a` and `b` as a pair to multiply this cycle |
| a | input | W | Multiplicand, unsigned |
| b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | Marks `product` as a new result this cycle |
| product | output | 2W | Unsigned product, registered |

## Verification
A pair applied before edge N is due on the outputs right after edge N+W. With W=4 that is five cycles and with W=6 it is seven. The bench stamps each accepted pair with the edge count at capture and records the reference product. On every falling edge it checks that an arriving result has exactly stamp+W+1 elapsed edges and the expected value, in order. It also flags any pending result that has become overdue without appearing. On falling edges without a result it checks that the product held its value. The assertions follow the valid flag one register at a time, so no check has to look back a parameter-sized distance.

// File: rtl/mult_pkg.sv
package mult_pkg;

  // One-bit full-adder sum output.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // One-bit full-adder carry output (majority of the three inputs).
  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/mult_pp_gen.sv
module mult_pp_gen #(
  parameter int W = 4
) (
  input  logic [W-1:0] mcand,
  input  logic         mbit,
  output logic [W-1:0] pp
);

  // One AND gate per column: partial-product bit = multiplier bit AND multiplicand bit.
  for (genvar j = 0; j < W; j++) begin : g_and
    assign pp[j] = mcand[j] & mbit;
  end

endmodule

// File: rtl/mult_csa_row.sv
module mult_csa_row
  import mult_pkg::*;
#(
  parameter int W   = 4,
  parameter int ROW = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic [W-1:0] mcand,
  input  logic         mbit,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] l_i,
  output logic         v_o,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] l_o
);

  logic [W-1:0] pp;
  logic [W-1:0] fsum;
  logic [W-1:0] fcar;
  logic [W-1:0] s_next;
  logic [W-1:0] l_next;

  mult_pp_gen #(.W(W)) u_pp (
    .mcand (mcand),
    .mbit  (mbit),
    .pp    (pp)
  );

  // Carry-save row. Every column adds incoming sum, incoming carry and partial-product bit.
  always_comb begin
    for (int j = 0; j < W; j++) begin
      fsum[j] = fa_sum(s_i[j], c_i[j], pp[j]);
      fcar[j] = fa_carry(s_i[j], c_i[j], pp[j]);
    end
  end

  // Column 0 is now final and is peeled off into product bit ROW.
  // The remaining sums move down one weight. The carries already sit one column higher.
  assign s_next = {1'b0, fsum[W-1:1]};

  always_comb begin
    l_next      = l_i;
    l_next[ROW] = fsum[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      s_o <= '0;
      c_o <= '0;
      l_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        s_o <= s_next;
        c_o <= fcar;
        l_o <= l_next;
      end
    end
  end

endmodule

// File: rtl/mult_final_add.sv
module mult_final_add
  import mult_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_i,
  input  logic [W-1:0]   s_i,
  input  logic [W-1:0]   c_i,
  input  logic [W-1:0]   l_i,
  output logic           cout,
  output logic           out_valid,
  output logic [2*W-1:0] product
);

  logic [W-1:0] hi;

  // Ripple carry-propagate adder that merges the last sum and carry vectors.
  always_comb begin
    logic cy;
    cy = 1'b0;
    for (int j = 0; j < W; j++) begin
      hi[j] = fa_sum(s_i[j], c_i[j], cy);
      cy    = fa_carry(s_i[j], c_i[j], cy);
    end
    cout = cy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= v_i;
      if (v_i) product <= {hi, l_i};
    end
  end

endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);

  localparam int ROWS  = W;
  localparam int OPDLY = W - 1;

  // Stage state after each carry-save row.
  logic [W-1:0] st_s [ROWS];
  logic [W-1:0] st_c [ROWS];
  logic [W-1:0] st_l [ROWS];
  logic [ROWS-1:0] stage_valid;

  // Multiplicand delayed to line up with each later row.
  logic [W-1:0] st_a [OPDLY];
  // Multiplier bit k, delayed k cycles for row k.
  logic [ROWS-1:0] row_b;

  // Named internal events for the checker.
  logic cpa_cout;
  logic low0;

  assign low0 = st_l[0][0];

  // Multiplicand delay chain.
  for (genvar k = 0; k < OPDLY; k++) begin : g_adly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_a[k] <= '0;
      else if (k == 0) st_a[k] <= a;
      else st_a[k] <= st_a[(k == 0) ? 0 : k-1];
    end
  end

  // Triangular multiplier-bit delay: row k sees b[k] from k cycles earlier.
  for (genvar k = 0; k < ROWS; k++) begin : g_bdly
    if (k == 0) begin : g_d0
      assign row_b[k] = b[0];
    end else if (k == 1) begin : g_d1
      logic dly;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly <= 1'b0;
        else dly <= b[1];
      end
      assign row_b[k] = dly;
    end else begin : g_dn
      logic [k-1:0] dly;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly <= '0;
        else dly <= {dly[k-2:0], b[k]};
      end
      assign row_b[k] = dly[k-1];
    end
  end

  // Carry-save rows, each followed by a register stage.
  for (genvar k = 0; k < ROWS; k++) begin : g_row
    if (k == 0) begin : g_first
      mult_csa_row #(.W(W), .ROW(0)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (in_valid),
        .mcand (a),
        .mbit  (row_b[0]),
        .s_i   ({W{1'b0}}),
        .c_i   ({W{1'b0}}),
        .l_i   ({W{1'b0}}),
        .v_o   (stage_valid[0]),
        .s_o   (st_s[0]),
        .c_o   (st_c[0]),
        .l_o   (st_l[0])
      );
    end else begin : g_next
      mult_csa_row #(.W(W), .ROW(k)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (stage_valid[k-1]),
        .mcand (st_a[k-1]),
        .mbit  (row_b[k]),
        .s_i   (st_s[k-1]),
        .c_i   (st_c[k-1]),
        .l_i   (st_l[k-1]),
        .v_o   (stage_valid[k]),
        .s_o   (st_s[k]),
        .c_o   (st_c[k]),
        .l_o   (st_l[k])
      );
    end
  end

  mult_final_add #(.W(W)) u_cpa (
    .clk       (clk),
    .rst_n     (rst_n),
    .v_i       (stage_valid[ROWS-1]),
    .s_i       (st_s[ROWS-1]),
    .c_i       (st_c[ROWS-1]),
    .l_i       (st_l[ROWS-1]),
    .cout      (cpa_cout),
    .out_valid (out_valid),
    .product   (product)
  );

endmodule

// File: rtl/mult_checker.sv
module mult_checker #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [W-1:0]   stage_valid,
  input logic           low0,
  input logic           cpa_cout,
  input logic           out_valid,
  input logic [2*W-1:0] product
);

  // R2: the valid flag enters the first stage one edge after sampling.
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> stage_valid[0]);
  p_enter_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !stage_valid[0]);

  // R2, R3: the flag moves one stage per cycle, with no loss and no duplication.
  for (genvar k = 1; k < W; k++) begin : g_step
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stage_valid[k-1] |=> stage_valid[k]);
    p_step_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_valid[k-1] |=> !stage_valid[k]);
  end

  p_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[W-1] |=> out_valid);
  p_exit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_valid[W-1] |=> !out_valid);

  // R1: the first resolved product bit equals a[0] AND b[0].
  p_low_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (low0 == $past(a[0] & b[0])));

  // R5: the product holds when no result is presented.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(product));

  // R6: the final adder never carries out of the product width.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[W-1] |-> !cpa_cout);

endmodule

bind csa_array_mult mult_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .a           (a),
  .b           (b),
  .stage_valid (stage_valid),
  .low0        (low0),
  .cpa_cout    (cpa_cout),
  .out_valid   (out_valid),
  .product     (product)
);

// File: tb/sim_csa_array_mult.sv
`timescale 1ns/1ps

module mult_scoreboard #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           out_valid,
  input  logic [2*W-1:0] product,
  output int             n_chk,
  output int             n_err,
  output int             pend
);

  localparam int DEPTH = 64;

  // Shift-and-add reference, written independently of the design.
  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++)
      if (y[i]) acc = acc + ({{W{1'b0}}, x} << i);
    return acc;
  endfunction

  logic [2*W-1:0] p_r [DEPTH];
  int             t_r [DEPTH];
  bit             m_r [DEPTH];
  int             wr  = 0;
  int             rd  = 0;
  int             cyc = 0;
  logic [2*W-1:0] last = '0;

  initial begin
    n_chk = 0;
    n_err = 0;
    pend  = 0;
  end

  always @(posedge clk) begin
    if (rst_n && in_valid) begin
      p_r[wr % DEPTH] <= ref_mul(a, b);
      t_r[wr % DEPTH] <= cyc;
      m_r[wr % DEPTH] <= (a == {W{1'b1}}) && (b == {W{1'b1}});
      wr <= wr + 1;
    end
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (rd == wr) begin
          n_chk = n_chk + 1;
          n_err = n_err + 1;
          $display("FAIL R2 W=%0d out_valid with nothing pending: actual 1 expected 0", W);
        end else begin
          n_chk = n_chk + 1;
          if (product !== p_r[rd % DEPTH]) begin
            n_err = n_err + 1;
            $display("FAIL R1 R3 W=%0d product: actual %0h expected %0h", W, product, p_r[rd % DEPTH]);
          end
          n_chk = n_chk + 1;
          if (cyc != t_r[rd % DEPTH] + W + 1) begin
            n_err = n_err + 1;
            $display("FAIL R2 W=%0d latency: actual %0d expected %0d", W, cyc - t_r[rd % DEPTH], W + 1);
          end
          if (m_r[rd % DEPTH]) begin
            n_chk = n_chk + 1;
            if (product !== {{(W-1){1'b1}}, {W{1'b0}}, 1'b1}) begin
              n_err = n_err + 1;
              $display("FAIL R6 W=%0d max product: actual %0h expected %0h", W, product,
                       {{(W-1){1'b1}}, {W{1'b0}}, 1'b1});
            end
          end
          rd = rd + 1;
        end
        last = product;
      end else begin
        n_chk = n_chk + 1;
        if (product !== last) begin
          n_err = n_err + 1;
          $display("FAIL R5 W=%0d product changed without valid: actual %0h expected %0h", W, product, last);
        end
        if (rd != wr && cyc >= t_r[rd % DEPTH] + W + 1) begin
          n_chk = n_chk + 1;
          n_err = n_err + 1;
          $display("FAIL R2 W=%0d result overdue: actual out_valid 0 expected 1", W);
          rd = rd + 1;
        end
      end
      pend = wr - rd;
    end
  end

endmodule

module sim_csa_array_mult;

  localparam int W4 = 4;
  localparam int W6 = 6;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W4-1:0] a4 = '0, b4 = '0;
  logic [W6-1:0] a6 = '0, b6 = '0;
  logic ov4, ov6;
  logic [2*W4-1:0] p4;
  logic [2*W6-1:0] p6;

  int chk = 0;
  int err = 0;
  int c0, e0, q0, c1, e1, q1;

  always #5 clk = ~clk;

  csa_array_mult #(.W(W4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a4), .b(b4),
    .out_valid(ov4), .product(p4)
  );

  csa_array_mult #(.W(W6)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a6), .b(b6),
    .out_valid(ov6), .product(p6)
  );

  mult_scoreboard #(.W(W4)) sb0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a4), .b(b4),
    .out_valid(ov4), .product(p4), .n_chk(c0), .n_err(e0), .pend(q0)
  );

  mult_scoreboard #(.W(W6)) sb1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a6), .b(b6),
    .out_valid(ov6), .product(p6), .n_chk(c1), .n_err(e1), .pend(q1)
  );

  task automatic put(input logic v, input logic [W4-1:0] x4, input logic [W4-1:0] y4,
                     input logic [W6-1:0] x6, input logic [W6-1:0] y6);
    @(negedge clk);
    in_valid = v;
    a4 = x4; b4 = y4;
    a6 = x6; b6 = y6;
  endtask

  task automatic check_reset(input string when);
    chk = chk + 1;
    if (ov4 !== 1'b0 || p4 !== '0 || ov6 !== 1'b0 || p6 !== '0) begin
      err = err + 1;
      $display("FAIL R4 %s: actual ov=%b%b p4=%0h p6=%0h expected 00 0 0", when, ov4, ov6, p4, p6);
    end
  endtask

  task automatic run_main();
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_reset("during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_reset("after release");

    // Directed corner cases (R1, R6): zero, ones, max, single bits.
    put(1, 4'h0, 4'h0, 6'h00, 6'h00);
    put(1, 4'hF, 4'hF, 6'h3F, 6'h3F);
    put(1, 4'hF, 4'h1, 6'h3F, 6'h01);
    put(1, 4'h1, 4'hF, 6'h01, 6'h3F);
    put(1, 4'h0, 4'hF, 6'h00, 6'h3F);
    put(1, 4'h8, 4'h8, 6'h20, 6'h20);
    put(0, 4'h5, 4'h3, 6'h15, 6'h0B);
    put(1, 4'hB, 4'hE, 6'h2B, 6'h3E);
    put(0, 4'h0, 4'h0, 6'h00, 6'h00);
    repeat (10) put(0, 4'h0, 4'h0, 6'h00, 6'h00);

    // Random with bubbles (R1, R2, R5).
    for (int i = 0; i < 400; i++)
      put(($urandom % 4) != 0, 4'($urandom), 4'($urandom), 6'($urandom), 6'($urandom));

    // Back-to-back stream, one pair every cycle (R3).
    for (int i = 0; i < 150; i++)
      put(1, 4'($urandom), 4'($urandom), 6'($urandom), 6'($urandom));

    // Drain.
    repeat (12) put(0, 4'h0, 4'h0, 6'h00, 6'h00);

    chk = chk + 1;
    if (q0 != 0 || q1 != 0) begin
      err = err + 1;
      $display("FAIL R3 results left pending: actual %0d/%0d expected 0/0", q0, q1);
    end
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (LIMIT) @(posedge clk);
        chk = chk + 1;
        err = err + 1;
        $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", LIMIT, LIMIT);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", chk + c0 + c1, err + e0 + e1);
    $finish;
  end

endmodule